// File: doc/BRIEF.md
# Protected-Register Unlock Sequencer

This block gates a group of write-protected control bits behind a three-byte key sequence. It watches a simple register bus (address, write strobe, read strobe, write data, read data) and tracks writes to one key register address. When the three key bytes arrive there in order, with no other bus access between them, it sets an unlock flag. The flag drives the write enable of the protected registers and can be read back from the key register as a single bit.

Idle bus cycles between key writes are allowed. A read of any address, or a write to any other address, ends a partial attempt. A wrong byte at any step also ends it, except that the first key byte always starts a new attempt. While unlocked, a write of any value to the key register clears the flag and relocks the bits. Reset clears both the flag and the partial sequence.

Top module: `prot_unlock_seq`

## Requirements
- R1: After synchronous reset `unlock_o` is 0, and a read of the key register returns 0.
- R2: Writes of 0x59, then 0x16, then 0x88 to address `LOCK_ADDR` while locked set `unlock_o` at the clock edge that takes the third write. No other order of three writes from a clean start sets it.
- R3: Cycles with neither `bus_wr` nor `bus_rd` asserted between key writes do not break a partial sequence.
- R4: While locked, a read of any address or a write to an address other than `LOCK_ADDR` discards a partial sequence. The full three-byte sequence must then be written again.
- R5: While locked, a write to `LOCK_ADDR` of a byte that is not the expected next key discards the partial sequence. If that byte is 0x59, it counts as the first key byte of a new attempt, so 0x59,0x59,0x16,0x88 and 0x59,0x16,0x59,0x16,0x88 both unlock.
- R6: `bus_rdata` is combinational. It equals `unlock_o` in bit 0, with all upper bits 0, while `bus_rd` is high and `bus_addr` equals `LOCK_ADDR`. It is 0 for a read of any other address.
- R7: While unlocked, a write of any value to `LOCK_ADDR` clears `unlock_o` at that clock edge.
- R8: While unlocked, reads, idle cycles and writes to other addresses leave `unlock_o` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | DATA_W | Write data; the key is compared on bits 7:0 |
| bus_rdata | output | DATA_W | Combinational read data |
| unlock_o | output | 1 | Unlock flag; write enable for the protected registers |

## Verification
The bench sweeps every three-write ordering over an alphabet of key and non-key bytes from a clean start. A tracker that accepts keys out of order, or that only checks the last byte, unlocks on a wrong triple. It also places each kind of interfering access between each pair of key writes. A design that ignores reads or writes to other addresses would unlock where it must not, and one that treats idle cycles as interference would refuse a valid attempt. The 0x59 restart cases catch a tracker that drops to idle on a repeated first byte. The relock sweep over many values catches a design that relocks only on particular data, and the hold checks catch one that relocks on any access.

// File: rtl/prot_unlock_pkg.sv
package prot_unlock_pkg;

    localparam logic [7:0] KEY_FIRST  = 8'h59;
    localparam logic [7:0] KEY_SECOND = 8'h16;
    localparam logic [7:0] KEY_THIRD  = 8'h88;

    typedef enum logic [1:0] {
        STEP_IDLE = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_TWO  = 2'd2
    } step_t;

    typedef enum logic [1:0] {
        ACC_NONE      = 2'd0,
        ACC_KEY_WRITE = 2'd1,
        ACC_KEY_READ  = 2'd2,
        ACC_FOREIGN   = 2'd3
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t  kind;
        logic [7:0] byte_val;
    } bus_event_t;

    typedef struct packed {
        step_t step;
        logic  unlocked;
    } track_state_t;

    // Next tracker state for a key-register write while locked.
    function automatic track_state_t key_advance(step_t cur, logic [7:0] val);
        track_state_t nxt;
        nxt.unlocked = 1'b0;
        nxt.step     = STEP_IDLE;
        if (cur == STEP_TWO && val == KEY_THIRD) begin
            nxt.unlocked = 1'b1;
        end else if (cur == STEP_ONE && val == KEY_SECOND) begin
            nxt.step = STEP_TWO;
        end else if (val == KEY_FIRST) begin
            nxt.step = STEP_ONE;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/prot_unlock_classify.sv
module prot_unlock_classify
    import prot_unlock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_event_t        evt
);
    logic hit;

    always_comb begin
        hit          = (bus_addr == LOCK_ADDR);
        evt.byte_val = bus_wdata[7:0];
        if (bus_wr && hit) begin
            evt.kind = ACC_KEY_WRITE;
        end else if (bus_rd && hit) begin
            evt.kind = ACC_KEY_READ;
        end else if (bus_wr || bus_rd) begin
            evt.kind = ACC_FOREIGN;
        end else begin
            evt.kind = ACC_NONE;
        end
    end
endmodule

// File: rtl/prot_unlock_tracker.sv
module prot_unlock_tracker
    import prot_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_event_t evt,
    output logic       unlocked
);
    track_state_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (cur_q.unlocked) begin
            if (evt.kind == ACC_KEY_WRITE) begin
                nxt.unlocked = 1'b0;
                nxt.step     = STEP_IDLE;
            end
        end else begin
            unique case (evt.kind)
                ACC_KEY_WRITE: nxt = key_advance(cur_q.step, evt.byte_val);
                ACC_KEY_READ,
                ACC_FOREIGN:   nxt.step = STEP_IDLE;
                default:       nxt = cur_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.unlocked <= 1'b0;
            cur_q.step     <= STEP_IDLE;
        end else begin
            cur_q <= nxt;
        end
    end

    assign unlocked = cur_q.unlocked;
endmodule

// File: rtl/prot_unlock_readback.sv
module prot_unlock_readback
    import prot_unlock_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bus_event_t        evt,
    input  logic              unlocked,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (evt.kind == ACC_KEY_READ) begin
            rdata[0] = unlocked;
        end
    end
endmodule

// File: rtl/prot_unlock_seq.sv
module prot_unlock_seq
    import prot_unlock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              unlock_o
);
    bus_event_t evt;
    logic       flag;

    prot_unlock_classify #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
    ) classify_i (
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .evt(evt)
    );

    prot_unlock_tracker tracker_i (
        .clk(clk), .rst(rst), .evt(evt), .unlocked(flag)
    );

    prot_unlock_readback #(.DATA_W(DATA_W)) readback_i (
        .evt(evt), .unlocked(flag), .rdata(bus_rdata)
    );

    assign unlock_o = flag;
endmodule

// File: rtl/prot_unlock_seq_chk.sv
module prot_unlock_seq_chk
    import prot_unlock_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h40
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              unlock_o
);
    logic key_wr;
    assign key_wr = bus_wr && (bus_addr == LOCK_ADDR);

    assert_reset_clear_R1: assert property (@(posedge clk)
        disable iff (rst) $past(rst) |-> !unlock_o);

    assert_rise_needs_third_key_R2: assert property (@(posedge clk)
        disable iff (rst) $rose(unlock_o) |-> $past(key_wr && bus_wdata[7:0] == KEY_THIRD));

    assert_idle_no_unlock_R3: assert property (@(posedge clk)
        disable iff (rst) (!unlock_o && !bus_wr && !bus_rd) |=> !unlock_o);

    assert_interfere_no_unlock_R4: assert property (@(posedge clk)
        disable iff (rst) (!unlock_o && !bus_wr && bus_rd) |=> !unlock_o);

    assert_wrong_byte_no_unlock_R5: assert property (@(posedge clk)
        disable iff (rst) (!unlock_o && key_wr && bus_wdata[7:0] != KEY_THIRD) |=> !unlock_o);

    assert_readback_bit_R6: assert property (@(posedge clk)
        disable iff (rst) (bus_rd && !bus_wr && bus_addr == LOCK_ADDR)
            |-> (bus_rdata == DATA_W'(unlock_o)));

    assert_relock_R7: assert property (@(posedge clk)
        disable iff (rst) (unlock_o && key_wr) |=> !unlock_o);

    assert_hold_unlocked_R8: assert property (@(posedge clk)
        disable iff (rst) (unlock_o && !key_wr) |=> unlock_o);
endmodule

bind prot_unlock_seq prot_unlock_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR)
) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unlock_o(unlock_o)
);

// File: tb/prot_unlock_seq_tb_top.sv
module prot_unlock_seq_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam logic [7:0] LOCK = 8'h40;
    localparam logic [7:0] OTHER = 8'h41;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              unlock_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    prot_unlock_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .unlock_o(unlock_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle; outputs settle 1 ns after the capturing edge.
    task automatic acc(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp));
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
    endtask

    task automatic clean_start();
        if (unlock_o) acc(1'b1, 1'b0, LOCK, 8'h00);
        acc(1'b0, 1'b1, OTHER, 8'h00);
    endtask

    task automatic key_wr(input logic [7:0] d);
        acc(1'b1, 1'b0, LOCK, d);
    endtask

    task automatic interfere(input int kind);
        case (kind)
            0: acc(1'b0, 1'b0, OTHER, 8'h00);
            1: acc(1'b0, 1'b1, LOCK, 8'h00);
            2: acc(1'b0, 1'b1, OTHER, 8'h00);
            default: acc(1'b1, 1'b0, OTHER, 8'h59);
        endcase
    endtask

    task automatic full_unlock();
        key_wr(8'h59); key_wr(8'h16); key_wr(8'h88);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [7:0] alpha [5];
        alpha[0] = 8'h59; alpha[1] = 8'h16; alpha[2] = 8'h88;
        alpha[3] = 8'h00; alpha[4] = 8'hFF;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1 reset flag", 32'(unlock_o), 32'd0);
        rd_chk("R1 reset readback", LOCK, 8'h00);

        // R1: reset in the middle of a sequence clears the tracker
        key_wr(8'h59); key_wr(8'h16);
        @(negedge clk); rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
        key_wr(8'h88);
        chk("R1 reset clears partial", 32'(unlock_o), 32'd0);
        full_unlock();
        @(negedge clk); rst = 1'b1; @(posedge clk); #1 rst = 1'b0;
        chk("R1 reset clears flag", 32'(unlock_o), 32'd0);

        // R2: every ordered triple from a clean start
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int k = 0; k < 5; k++) begin
                    clean_start();
                    key_wr(alpha[i]);
                    chk("R2 no early unlock", 32'(unlock_o), 32'd0);
                    key_wr(alpha[j]);
                    chk("R2 no early unlock", 32'(unlock_o), 32'd0);
                    key_wr(alpha[k]);
                    chk("R2 triple", 32'(unlock_o), 32'(i == 0 && j == 1 && k == 2));
                end

        // R3/R4: each interference kind at each gap
        for (int gap = 0; gap < 2; gap++)
            for (int kind = 0; kind < 4; kind++) begin
                clean_start();
                key_wr(8'h59);
                if (gap == 0) interfere(kind);
                key_wr(8'h16);
                if (gap == 1) interfere(kind);
                key_wr(8'h88);
                if (kind == 0) chk("R3 idle gap keeps sequence", 32'(unlock_o), 32'd1);
                else           chk("R4 access aborts sequence", 32'(unlock_o), 32'd0);
            end

        // R4: after an abort the full sequence unlocks again
        clean_start();
        key_wr(8'h59); interfere(2); full_unlock();
        chk("R4 restart after abort", 32'(unlock_o), 32'd1);

        // R5: restart rules
        clean_start();
        key_wr(8'h59); key_wr(8'h59); key_wr(8'h16); key_wr(8'h88);
        chk("R5 repeated first key", 32'(unlock_o), 32'd1);
        clean_start();
        key_wr(8'h59); key_wr(8'h16); key_wr(8'h59); key_wr(8'h16); key_wr(8'h88);
        chk("R5 first key at step three", 32'(unlock_o), 32'd1);
        clean_start();
        key_wr(8'h59); key_wr(8'h16); key_wr(8'h16); key_wr(8'h88);
        chk("R5 wrong byte aborts", 32'(unlock_o), 32'd0);
        clean_start();
        key_wr(8'h59); key_wr(8'h16); key_wr(8'h00); key_wr(8'h88);
        chk("R5 wrong byte no recovery", 32'(unlock_o), 32'd0);

        // R6: readback
        clean_start();
        rd_chk("R6 locked read", LOCK, 8'h00);
        full_unlock();
        rd_chk("R6 unlocked read", LOCK, 8'h01);
        rd_chk("R6 other address read", OTHER, 8'h00);
        rd_chk("R6 unlocked read again", LOCK, 8'h01);

        // R8: non-key accesses while unlocked keep the flag
        for (int kind = 0; kind < 4; kind++) begin
            interfere(kind);
            chk("R8 hold while unlocked", 32'(unlock_o), 32'd1);
        end

        // R7: any value written to the key register relocks
        for (int v = 0; v < 256; v += 17) begin
            clean_start();
            full_unlock();
            key_wr(8'(v));
            chk("R7 relock", 32'(unlock_o), 32'd0);
            rd_chk("R7 relock readback", LOCK, 8'h00);
        end
        clean_start();
        full_unlock();
        key_wr(8'h88);
        chk("R7 relock on third key", 32'(unlock_o), 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule